// File: doc/BRIEF.md
# Branch and Move Condition Evaluator

This block decides whether a conditional instruction takes effect. It receives the 4-bit function code carried by either a conditional register move or a conditional jump, plus the three stored condition flags (zero, negative, overflow). It returns one bit that says whether the condition holds. A conditional move uses that bit to gate its register write, so the destination keeps its old value when the bit is low. A jump uses it to choose between the branch target and the sequential address after the 5-byte jump instruction.

Moves and jumps share one evaluator because both instruction families use the same seven condition codes. Code 0 is unconditional. The remaining function codes, 7 through 15, are reported as invalid and never yield a true condition. The block is purely combinational. It has no clock, no reset and no state, so the outputs follow the current inputs directly.

Internally a relation stage computes all seven condition terms from the flags in parallel. A selector stage decodes the function code into a one-hot select plus an invalid flag. The top module ANDs each select bit with its term and reduces the result. There is no state machine.

Top module: `cond_eval`

## Requirements
- R1: Function code 0 (always) drives `cond_true` high for every combination of the three flags.
- R2: Function code 1 (less-or-equal) drives `cond_true` to (neg XOR ovf) OR zero.
- R3: Function code 2 (less) drives `cond_true` to neg XOR ovf.
- R4: Function code 3 (equal) drives `cond_true` to zero.
- R5: Function code 4 (not-equal) drives `cond_true` to NOT zero.
- R6: Function code 5 (greater-or-equal) drives `cond_true` to NOT (neg XOR ovf).
- R7: Function code 6 (greater) drives `cond_true` to NOT (neg XOR ovf) AND NOT zero.
- R8: Function codes 7 to 15 drive `cond_true` low and `cond_invalid` high, whatever the flags are.
- R9: Function codes 0 to 6 drive `cond_invalid` low.
- R10: The outputs depend only on the present inputs. Applying the same input pattern again after any history gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_code | input | FN_W (4) | Function code field of the move or jump instruction |
| flag_zero | input | 1 | Stored zero flag |
| flag_neg | input | 1 | Stored negative (sign) flag |
| flag_ovf | input | 1 | Stored signed-overflow flag |
| cond_true | output | 1 | Condition holds: enables the move write or takes the jump |
| cond_invalid | output | 1 | Function code names no defined condition |

## Verification
The bench sweeps all 16 function codes against all 8 flag combinations and computes each expected bit arithmetically. This exposes any condition term that confuses the signed relations, for example one that uses the negative flag alone instead of XORing it with overflow. A design like that would give the wrong answer only when overflow is set, so the overflow-set rows are the ones that expose it. The sweep also targets the boundary between code 6 and code 7: an off-by-one decoder would either let code 7 report a true condition or flag the greater test as invalid. A second pass runs in reverse order to expose any output that depends on earlier inputs rather than on the present ones.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int NUM_CC = 7;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_LE     = 3'd1,
        CC_LT     = 3'd2,
        CC_EQ     = 3'd3,
        CC_NE     = 3'd4,
        CC_GE     = 3'd5,
        CC_GT     = 3'd6
    } cc_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/cc_relations.sv
module cc_relations
    import cond_eval_pkg::*;
(
    input  flags_t              flags,
    output logic [NUM_CC-1:0]   rel_vec
);

    logic signed_less;

    always_comb begin
        signed_less      = flags.neg ^ flags.ovf;
        rel_vec          = '0;
        rel_vec[CC_ALWAYS] = 1'b1;
        rel_vec[CC_LE]   = signed_less | flags.zero;
        rel_vec[CC_LT]   = signed_less;
        rel_vec[CC_EQ]   = flags.zero;
        rel_vec[CC_NE]   = ~flags.zero;
        rel_vec[CC_GE]   = ~signed_less;
        rel_vec[CC_GT]   = ~signed_less & ~flags.zero;
    end

endmodule

// File: rtl/cc_select.sv
module cc_select
    import cond_eval_pkg::*;
#(
    parameter int FN_W = 4
) (
    input  logic [FN_W-1:0]     fn_code,
    output logic [NUM_CC-1:0]   sel_vec,
    output logic                sel_invalid
);

    for (genvar i = 0; i < NUM_CC; i++) begin : g_sel
        assign sel_vec[i] = (fn_code == FN_W'(i));
    end

    assign sel_invalid = ~|sel_vec;

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
#(
    parameter int FN_W = 4
) (
    input  logic [FN_W-1:0] fn_code,
    input  logic            flag_zero,
    input  logic            flag_neg,
    input  logic            flag_ovf,
    output logic            cond_true,
    output logic            cond_invalid
);

    flags_t              flags;
    logic [NUM_CC-1:0]   rel_vec;
    logic [NUM_CC-1:0]   sel_vec;
    logic [NUM_CC-1:0]   hit_vec;
    logic                sel_invalid;

    assign flags = '{zero: flag_zero, neg: flag_neg, ovf: flag_ovf};

    cc_relations u_rel (
        .flags   (flags),
        .rel_vec (rel_vec)
    );

    cc_select #(.FN_W(FN_W)) u_sel (
        .fn_code     (fn_code),
        .sel_vec     (sel_vec),
        .sel_invalid (sel_invalid)
    );

    for (genvar i = 0; i < NUM_CC; i++) begin : g_hit
        assign hit_vec[i] = sel_vec[i] & rel_vec[i];
    end

    assign cond_true    = |hit_vec;
    assign cond_invalid = sel_invalid;

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
    parameter int FN_W = 4
) (
    input logic [FN_W-1:0] fn_code,
    input logic            flag_zero,
    input logic            flag_neg,
    input logic            flag_ovf,
    input logic            cond_true,
    input logic            cond_invalid
);

    always_comb begin
        // R1
        p_always_true_r1: assert (!(fn_code == FN_W'(0)) || cond_true);
        // R4 and R5: equal and not-equal are complementary on the zero flag
        p_equal_tracks_zero_r4: assert (!(fn_code == FN_W'(3)) || (cond_true == flag_zero));
        p_noteq_opposes_zero_r5: assert (!(fn_code == FN_W'(4)) || (cond_true != flag_zero));
        // R7: greater never holds when the zero flag is set
        p_greater_needs_nonzero_r7: assert (!(fn_code == FN_W'(6) && cond_true) || !flag_zero);
        // R8
        p_invalid_is_false_r8: assert (!cond_invalid || !cond_true);
        // R9 and R8: invalid exactly above code 6
        p_invalid_range_r9: assert (cond_invalid == (fn_code > FN_W'(6)));
    end

endmodule

bind cond_eval cond_eval_chk #(.FN_W(FN_W)) u_cond_eval_chk (
    .fn_code      (fn_code),
    .flag_zero    (flag_zero),
    .flag_neg     (flag_neg),
    .flag_ovf     (flag_ovf),
    .cond_true    (cond_true),
    .cond_invalid (cond_invalid)
);

// File: tb/cond_eval_bench.sv
module cond_eval_bench;

    localparam int FN_W = 4;

    logic            clk = 1'b0;
    logic [FN_W-1:0] fn_code = '0;
    logic            flag_zero = 1'b0;
    logic            flag_neg = 1'b0;
    logic            flag_ovf = 1'b0;
    logic            cond_true;
    logic            cond_invalid;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cond_eval #(.FN_W(FN_W)) u_cond_eval (
        .fn_code      (fn_code),
        .flag_zero    (flag_zero),
        .flag_neg     (flag_neg),
        .flag_ovf     (flag_ovf),
        .cond_true    (cond_true),
        .cond_invalid (cond_invalid)
    );

    function automatic string req_tag(int fn);
        case (fn)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply_and_check(input int fn, input int fl, input bit second_pass);
        bit z, s, o, lt, exp_true, exp_inv;
        string tag;
        z = fl[2]; s = fl[1]; o = fl[0];
        @(posedge clk);
        fn_code   <= FN_W'(fn);
        flag_zero <= z;
        flag_neg  <= s;
        flag_ovf  <= o;
        @(negedge clk);
        lt = s ^ o;
        case (fn)
            0: exp_true = 1'b1;
            1: exp_true = lt | z;
            2: exp_true = lt;
            3: exp_true = z;
            4: exp_true = !z;
            5: exp_true = !lt;
            6: exp_true = !lt & !z;
            default: exp_true = 1'b0;
        endcase
        exp_inv = (fn > 6);
        tag = second_pass ? "R10" : req_tag(fn);
        n_vec++;
        if (cond_true !== exp_true) begin
            n_fail++;
            $display("FAIL %s cond_true fn=%0d zf=%0b sf=%0b of=%0b got=%0b exp=%0b",
                     tag, fn, z, s, o, cond_true, exp_true);
        end
        if (cond_invalid !== exp_inv) begin
            n_fail++;
            $display("FAIL %s cond_invalid (R9 when fn<7) fn=%0d got=%0b exp=%0b",
                     tag, fn, cond_invalid, exp_inv);
        end
    endtask

    initial begin
        for (int fn = 0; fn < 16; fn++) begin
            for (int fl = 0; fl < 8; fl++) begin
                apply_and_check(fn, fl, 1'b0);
            end
        end
        // R10: reverse order, results must match the forward pass
        for (int fn = 15; fn >= 0; fn--) begin
            for (int fl = 7; fl >= 0; fl--) begin
                apply_and_check(fn, fl, 1'b1);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got=hang exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule